// File: doc/BRIEF.md
# TDM Output Channel Mode Stage

This block drives a set of serial time-division-multiplexed output streams. Each stream carries frames of 32 eight-bit channels, one bit per clock. Every output channel has its own control entry, which picks where that channel's byte comes from. In connection mode the byte is read from a received-data memory at a source address held in the entry. In message mode the byte is a constant held in the entry itself, and it repeats in every frame. Connection mode can also be qualified with a float flag, which releases the line for the whole slot.

A frame pulse aligns the channel and bit counters. Each channel's byte is fetched one full channel time before it goes out and is parked in a holding register. At the slot boundary it moves into a parallel-to-serial shifter. Each stream has a data pin and an enable pin. A global active-low enable input floats every stream at once, whatever the channels are programmed to do. Two simple write ports fill the control memory and the received-data memory. Both memories are addressed as {stream, channel}, with the stream in bit 5 and the channel in bits 4:0.

Top module: `tdm_out_stage`

## Requirements
- R1: When `frame_i` is high at a clock edge, the next cycle carries channel 0, bit 7 on every stream. Bits then follow at one per clock, eight per channel, through channel 31, and wrap to channel 0 without another pulse. A pulse arriving mid-frame restarts this sequence.
- R2: Each channel byte leaves the stream most significant bit first.
- R3: A control entry with bit 9 = 0 and bit 8 = 0 selects connection mode. Its bits 5:0 give a received-data address (bit 5 is the stream, bits 4:0 the channel), and that memory location is sent in the slot. Bits 7:6 are ignored in this mode.
- R4: A control entry with bit 9 = 1 selects message mode. Its bits 7:0 are sent in the slot, in every frame, until the entry is rewritten.
- R5: A control entry with bit 9 = 0 and bit 8 = 1 holds `ser_oe_o` low for all eight bits of that slot. With bit 9 = 1, bit 8 has no effect and the message byte is driven.
- R6: While `out_en_i` is low, `ser_oe_o` is low on every stream. `ser_o` reads 0 whenever its enable is low. When `out_en_i` returns high, the stream resumes at its current bit position.
- R7: The entries for channel k are read at the clock edge that begins slot k-1. A write accepted before that edge is used in the coming frame. A write accepted on that edge or later, including one during slot k itself, takes effect only from the next frame, and never in the middle of a byte.
- R8: After reset and until the first frame pulse, every `ser_oe_o` is low and every `ser_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_i | input | 1 | Frame alignment pulse |
| out_en_i | input | 1 | Global enable, low floats all streams |
| ctl_we_i | input | 1 | Control memory write strobe |
| ctl_addr_i | input | 6 | Control entry address {stream, channel} |
| ctl_wdata_i | input | 10 | Entry: bit 9 message, bit 8 float, bits 7:0 field |
| rx_we_i | input | 1 | Received-data memory write strobe |
| rx_addr_i | input | 6 | Received-data address {stream, channel} |
| rx_data_i | input | 8 | Received byte |
| ser_o | output | 2 | Serial data, one bit per stream |
| ser_oe_o | output | 2 | Per-stream output enable |

## Verification
The collision of interest is a control write landing on the same edge as the fetch of that very entry. The fetch must still see the old contents, and the new value must appear one frame later. The bench places rewrites one cycle before a channel's fetch edge, exactly on it, and in the middle of the channel's own slot. It then compares two consecutive frames bit by bit against a model that applies each write to the frame it should reach. Separately, the global disable is dropped across slot boundaries and a frame pulse is raised mid-frame. This confirms that the shifter keeps its position and that re-alignment restarts at channel 0, bit 7.

// File: rtl/tdm_out_pkg.sv
package tdm_out_pkg;
   localparam int BYTE_W = 8;

   typedef struct packed {
      logic               msg;
      logic               hiz;
      logic [BYTE_W-1:0]  field;
   } ctl_t;

   typedef struct packed {
      logic               flt;
      logic [BYTE_W-1:0]  dat;
   } slot_t;

   function automatic slot_t resolve_slot(ctl_t c, logic [BYTE_W-1:0] rx);
      slot_t r;
      r.flt = !c.msg && c.hiz;
      r.dat = c.msg ? c.field : rx;
      return r;
   endfunction
endpackage

// File: rtl/tdm_out_ram.sv
module tdm_out_ram #(
   parameter int W     = 8,
   parameter int DEPTH = 64,
   parameter int NRD   = 2,
   localparam int AW   = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we_i,
   input  logic [AW-1:0]     waddr_i,
   input  logic [W-1:0]      wdata_i,
   input  logic [NRD*AW-1:0] raddr_i,
   output logic [NRD*W-1:0]  rdata_o
);
   logic [W-1:0] mem_q [DEPTH];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
      end else if (we_i) begin
         mem_q[waddr_i] <= wdata_i;
      end
   end

   for (genvar g = 0; g < NRD; g++) begin : g_rd
      assign rdata_o[g*W +: W] = mem_q[raddr_i[g*AW +: AW]];
   end
endmodule

// File: rtl/tdm_out_timebase.sv
module tdm_out_timebase #(
   parameter int NCH    = 32,
   parameter int BYTE_W = 8,
   localparam int CH_W  = $clog2(NCH),
   localparam int BIT_W = $clog2(BYTE_W)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            frame_i,
   output logic            active_o,
   output logic            load_o,
   output logic [CH_W-1:0] now_ch_o,
   output logic [CH_W-1:0] ahead_ch_o
);
   localparam logic [BIT_W-1:0] BIT_TOP = BIT_W'(BYTE_W-1);
   localparam logic [CH_W-1:0]  CH_LAST = CH_W'(NCH-1);

   logic            act_q;
   logic [CH_W-1:0] chan_q;
   logic [BIT_W-1:0] bit_q;

   always_comb begin
      if (frame_i)               now_ch_o = '0;
      else if (chan_q == CH_LAST) now_ch_o = '0;
      else                        now_ch_o = chan_q + 1'b1;
      ahead_ch_o = (now_ch_o == CH_LAST) ? '0 : now_ch_o + 1'b1;
   end

   assign load_o   = frame_i | (act_q & (bit_q == '0));
   assign active_o = act_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         act_q  <= 1'b0;
         chan_q <= '0;
         bit_q  <= '0;
      end else if (frame_i) begin
         act_q  <= 1'b1;
         chan_q <= '0;
         bit_q  <= BIT_TOP;
      end else if (act_q) begin
         if (bit_q == '0) begin
            chan_q <= now_ch_o;
            bit_q  <= BIT_TOP;
         end else begin
            bit_q  <= bit_q - 1'b1;
         end
      end
   end

   AST_FRAME_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
      frame_i |=> (chan_q == '0 && bit_q == BIT_TOP)); // R1
   AST_SLOT_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
      (act_q && !frame_i && bit_q == '0) |=>
      (bit_q == BIT_TOP && chan_q == (($past(chan_q) == CH_LAST) ? '0 : $past(chan_q) + 1'b1))); // R1
   AST_BIT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (act_q && !frame_i && bit_q != '0) |=> (bit_q == $past(bit_q) - 1'b1 && $stable(chan_q))); // R1
endmodule

// File: rtl/tdm_out_lane.sv
module tdm_out_lane
   import tdm_out_pkg::*;
(
   input  logic  clk,
   input  logic  rst_n,
   input  logic  frame_i,
   input  logic  load_i,
   input  logic  active_i,
   input  logic  en_i,
   input  slot_t now_i,
   input  slot_t ahead_i,
   output logic  ser_o,
   output logic  oe_o
);
   logic [BYTE_W-1:0] sh_q;
   logic              flt_q;
   slot_t             hold_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sh_q   <= '0;
         flt_q  <= 1'b1;
         hold_q <= '{flt: 1'b1, dat: '0};
      end else if (load_i) begin
         if (frame_i) begin
            sh_q  <= now_i.dat;
            flt_q <= now_i.flt;
         end else begin
            sh_q  <= hold_q.dat;
            flt_q <= hold_q.flt;
         end
         hold_q <= ahead_i;
      end else if (active_i) begin
         sh_q <= {sh_q[BYTE_W-2:0], 1'b0};
      end
   end

   assign oe_o  = active_i & ~flt_q & en_i;
   assign ser_o = oe_o & sh_q[BYTE_W-1];

   AST_MSB_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
      (active_i && !load_i) |=> (sh_q == {$past(sh_q[BYTE_W-2:0]), 1'b0})); // R2
   AST_HOLD_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
      !load_i |=> $stable(hold_q)); // R7
   AST_FLOAT_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
      !load_i |=> $stable(flt_q)); // R5
endmodule

// File: rtl/tdm_out_stage.sv
module tdm_out_stage
   import tdm_out_pkg::*;
#(
   parameter int NSTR   = 2,
   parameter int NCH    = 32,
   localparam int AW    = $clog2(NSTR) + $clog2(NCH),
   localparam int CW    = BYTE_W + 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              frame_i,
   input  logic              out_en_i,
   input  logic              ctl_we_i,
   input  logic [AW-1:0]     ctl_addr_i,
   input  logic [CW-1:0]     ctl_wdata_i,
   input  logic              rx_we_i,
   input  logic [AW-1:0]     rx_addr_i,
   input  logic [BYTE_W-1:0] rx_data_i,
   output logic [NSTR-1:0]   ser_o,
   output logic [NSTR-1:0]   ser_oe_o
);
   localparam int CH_W  = $clog2(NCH);
   localparam int STR_W = $clog2(NSTR);
   localparam int DEPTH = NSTR * NCH;
   localparam int NRD   = 2 * NSTR;

   if (NSTR < 2 || (NSTR & (NSTR - 1)) != 0) begin : g_bad_nstr
      $error("NSTR must be a power of two of at least 2");
   end
   if (NCH < 2 || (NCH & (NCH - 1)) != 0) begin : g_bad_nch
      $error("NCH must be a power of two of at least 2");
   end
   if (AW > BYTE_W) begin : g_bad_aw
      $error("source address does not fit in the entry field");
   end

   logic            active, load;
   logic [CH_W-1:0] now_ch, ahead_ch;
   logic [NRD*AW-1:0] ctl_raddr, rx_raddr;
   logic [NRD*CW-1:0] ctl_rdata;
   logic [NRD*BYTE_W-1:0] rx_rdata;

   tdm_out_timebase #(.NCH(NCH), .BYTE_W(BYTE_W)) u_timebase (
      .clk        (clk),
      .rst_n      (rst_n),
      .frame_i    (frame_i),
      .active_o   (active),
      .load_o     (load),
      .now_ch_o   (now_ch),
      .ahead_ch_o (ahead_ch)
   );

   tdm_out_ram #(.W(CW), .DEPTH(DEPTH), .NRD(NRD)) u_ctl_mem (
      .clk     (clk),
      .rst_n   (rst_n),
      .we_i    (ctl_we_i),
      .waddr_i (ctl_addr_i),
      .wdata_i (ctl_wdata_i),
      .raddr_i (ctl_raddr),
      .rdata_o (ctl_rdata)
   );

   tdm_out_ram #(.W(BYTE_W), .DEPTH(DEPTH), .NRD(NRD)) u_rx_mem (
      .clk     (clk),
      .rst_n   (rst_n),
      .we_i    (rx_we_i),
      .waddr_i (rx_addr_i),
      .wdata_i (rx_data_i),
      .raddr_i (rx_raddr),
      .rdata_o (rx_rdata)
   );

   for (genvar s = 0; s < NSTR; s++) begin : g_stream
      ctl_t  ctl_now, ctl_ahead;
      slot_t slot_now, slot_ahead;

      assign ctl_raddr[(2*s)*AW +: AW]   = {STR_W'(s), now_ch};
      assign ctl_raddr[(2*s+1)*AW +: AW] = {STR_W'(s), ahead_ch};
      assign ctl_now   = ctl_t'(ctl_rdata[(2*s)*CW +: CW]);
      assign ctl_ahead = ctl_t'(ctl_rdata[(2*s+1)*CW +: CW]);
      assign rx_raddr[(2*s)*AW +: AW]    = ctl_now.field[AW-1:0];
      assign rx_raddr[(2*s+1)*AW +: AW]  = ctl_ahead.field[AW-1:0];
      assign slot_now   = resolve_slot(ctl_now,   rx_rdata[(2*s)*BYTE_W +: BYTE_W]);
      assign slot_ahead = resolve_slot(ctl_ahead, rx_rdata[(2*s+1)*BYTE_W +: BYTE_W]);

      tdm_out_lane u_lane (
         .clk      (clk),
         .rst_n    (rst_n),
         .frame_i  (frame_i),
         .load_i   (load),
         .active_i (active),
         .en_i     (out_en_i),
         .now_i    (slot_now),
         .ahead_i  (slot_ahead),
         .ser_o    (ser_o[s]),
         .oe_o     (ser_oe_o[s])
      );
   end

   AST_IDLE_FLOAT: assert property (@(posedge clk) disable iff (!rst_n)
      !active |-> (ser_oe_o == '0 && ser_o == '0)); // R8
   AST_DISABLE_ALL: assert property (@(posedge clk) disable iff (!rst_n)
      !out_en_i |-> (ser_oe_o == '0)); // R6
endmodule

// File: tb/tdm_out_stage_bench.sv
module tdm_out_stage_bench;
   localparam int CLK_PERIOD = 10;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       frame_i = 1'b0;
   logic       out_en_i = 1'b1;
   logic       ctl_we_i = 1'b0;
   logic [5:0] ctl_addr_i = '0;
   logic [9:0] ctl_wdata_i = '0;
   logic       rx_we_i = 1'b0;
   logic [5:0] rx_addr_i = '0;
   logic [7:0] rx_data_i = '0;
   logic [1:0] ser_o, ser_oe_o;

   int n_chk = 0;
   int n_fail = 0;
   logic [9:0] m_ctl [64];
   logic [9:0] v_ctl [64];
   logic [7:0] m_rx  [64];
   logic [7:0] v_rx  [64];
   logic [7:0] asm_b [2];

   tdm_out_stage u_tdm_out_stage (
      .clk(clk), .rst_n(rst_n), .frame_i(frame_i), .out_en_i(out_en_i),
      .ctl_we_i(ctl_we_i), .ctl_addr_i(ctl_addr_i), .ctl_wdata_i(ctl_wdata_i),
      .rx_we_i(rx_we_i), .rx_addr_i(rx_addr_i), .rx_data_i(rx_data_i),
      .ser_o(ser_o), .ser_oe_o(ser_oe_o)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   task automatic check(string tag, logic [8:0] act, logic [8:0] exp, string what);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
      end
   endtask

   function automatic logic [8:0] exp_slot(int s, int c);
      logic [9:0] e;
      e = v_ctl[s*32 + c];
      return {(!e[9] && e[8]), (e[9] ? e[7:0] : v_rx[e[5:0]])};
   endfunction

   task automatic load_cfg(int variant);
      for (int a = 0; a < 64; a++) begin
         int s, c, md, src;
         logic [7:0] fld;
         s = a / 32; c = a % 32;
         if (variant == 0) begin
            md  = c % 4;
            src = ((c + s) % 2) * 32 + (c * 7 + 3) % 32;
            fld = (md % 2 == 1) ? 8'((c * 29 + s * 101 + 17) % 256) : 8'(src + ((c % 3) << 6));
            m_rx[a] = 8'((a * 37 + 5) % 256);
         end else begin
            md  = (c + 1) % 4;
            src = ((c + 1 + s) % 2) * 32 + (c * 11 + 9) % 32;
            fld = (md % 2 == 1) ? 8'((c * 53 + s * 77 + 200) % 256) : 8'(src);
            m_rx[a] = 8'((a * 91 + 60) % 256);
         end
         // md: 0 connection, 1 message, 2 connection+float, 3 message+float
         m_ctl[a] = {(md % 2 == 1), (md >= 2), fld};
         @(negedge clk);
         ctl_we_i = 1'b1; ctl_addr_i = 6'(a); ctl_wdata_i = m_ctl[a];
         rx_we_i  = 1'b1; rx_addr_i  = 6'(a); rx_data_i  = m_rx[a];
      end
      @(negedge clk);
      ctl_we_i = 1'b0; rx_we_i = 1'b0;
      for (int a = 0; a < 64; a++) begin v_ctl[a] = m_ctl[a]; v_rx[a] = m_rx[a]; end
   endtask

   task automatic idle_check(int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         check("R8", {7'd0, ser_oe_o}, 9'd0, "idle enables");
         check("R8", {7'd0, ser_o}, 9'd0, "idle data");
      end
   endtask

   task automatic run(int nobs, int scen);
      int pos = 0;
      int frame_no = 0;
      bit resynced = 0;
      bit pend = 0;
      @(negedge clk);
      frame_i = 1'b1;
      for (int i = 0; i < nobs; i++) begin
         int ch, b;
         @(negedge clk);
         frame_i = 1'b0; ctl_we_i = 1'b0; rx_we_i = 1'b0;
         if (pos == 0 && frame_no > 0)
            for (int a = 0; a < 64; a++) begin v_ctl[a] = m_ctl[a]; v_rx[a] = m_rx[a]; end
         ch = pos / 8; b = 7 - pos % 8;
         for (int s = 0; s < 2; s++) begin
            logic [8:0] e;
            logic eoe, eser;
            string tag;
            e = exp_slot(s, ch);
            eoe  = out_en_i && !e[8];
            eser = eoe && e[b];
            if (pos < 8 && (frame_no > 0 || resynced)) tag = "R1";
            else if (scen == 2 && ((s == 0 && (ch == 5 || ch == 6)) || (s == 1 && ch == 7))) tag = "R7";
            else if (!out_en_i) tag = "R6";
            else if (e[8]) tag = "R5";
            else if (v_ctl[s*32 + ch][9]) tag = "R4";
            else tag = "R3";
            check(tag, {7'd0, ser_oe_o[s], ser_o[s]}, {7'd0, eoe, eser},
                  $sformatf("frame%0d s%0d ch%0d bit%0d", frame_no, s, ch, b));
            asm_b[s] = {asm_b[s][6:0], ser_o[s]};
            if (scen == 0 && b == 0 && !e[8])
               check("R2", {1'b0, asm_b[s]}, {1'b0, e[7:0]},
                     $sformatf("byte order s%0d ch%0d", s, ch));
         end
         if (scen == 1) begin
            if (i == 40) out_en_i = 1'b0;
            if (i == 75) out_en_i = 1'b1;
            if (i == 150) begin frame_i = 1'b1; pend = 1; end
         end
         if (scen == 2) begin
            if (i == 30) begin
               m_ctl[5] = {2'b10, 8'h3C}; v_ctl[5] = m_ctl[5];
               ctl_we_i = 1'b1; ctl_addr_i = 6'd5; ctl_wdata_i = m_ctl[5];
            end
            if (i == 39) begin
               m_ctl[6] = {2'b10, 8'hA5};
               ctl_we_i = 1'b1; ctl_addr_i = 6'd6; ctl_wdata_i = m_ctl[6];
            end
            if (i == 58) begin
               m_ctl[39] = {2'b10, 8'h5A};
               ctl_we_i = 1'b1; ctl_addr_i = 6'd39; ctl_wdata_i = m_ctl[39];
            end
         end
         pos++;
         if (pos == 256) begin pos = 0; frame_no++; end
         if (pend) begin pos = 0; resynced = 1; pend = 0; end
      end
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      idle_check(4);
      load_cfg(0);
      idle_check(2);
      run(512, 0);      // two frames: modes, wrap, repetition, byte order
      load_cfg(1);
      run(211, 1);      // global disable window and mid-frame re-alignment
      run(512, 2);      // rewrites around fetch edges
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 100000);
      n_chk++;
      n_fail++;
      $display("FAIL R1 watchdog actual=running expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule